// File: doc/BRIEF.md
# Quadrature Position Counter with Selectable Clear Sources

This block turns the two phase channels of an incremental encoder into a signed position count. It can count in both directions. The channel inputs, the index input and a limit-switch input each pass through a two-flop synchroniser and then a filter that rejects short pulses. After that, a decoder counts steps at one, two or four counts per encoder cycle. The direction of each step comes from the phase relation of the two channels. A step in which both channels change together cannot be decoded. That step is dropped and a sticky error flag is raised.

Three sources can clear the count: the index pulse, the limit switch and a software request bit. A three-bit mask enables each source separately, in any combination, and the mask may change while counting runs. A run enable starts and stops counting. Clears still take effect while counting is stopped. The outputs are the count, the direction of the last counted step, a one-cycle clear indication and the error flag.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset `position` is 0, `dir_up` is 1, and `cleared` and `seq_err` are 0.
- R2: With `res_mode` = 2'b10 or 2'b11, every single-channel edge counts. An A edge counts up when A differs from B after the edge. A B edge counts up when B equals A after the edge. The forward cycle (A,B) = 00,10,11,01 therefore counts up, and the reverse cycle counts down.
- R3: With `res_mode` = 2'b01, only A edges count, up when A differs from B after the edge. B edges do not change the count.
- R4: With `res_mode` = 2'b00, only rising A edges count: up when B is 0, down when B is 1.
- R5: A filtered sample in which A and B both change is not counted. It sets `seq_err`, which stays set until reset.
- R6: While `run_en` is 0 the count holds. Enabled clear sources still clear it.
- R7: Bit 0 of `clr_mask` enables a clear on a rising edge of filtered `idx_in`. Bit 1 enables a clear on a rising edge of filtered `lim_in`. Bit 2 enables a clear on a 0-to-1 change of `sw_clr`. A clear sets `position` to 0, with `cleared` high for that one cycle.
- R8: A source whose mask bit is 0 has no effect on the count.
- R9: When a clear and a counted step occur in the same cycle, `position` becomes 0.
- R10: Changing `clr_mask` while counting does not alter the count or its progress.
- R11: The count wraps modulo 2^CNT_W: one down step from 0 gives all ones.
- R12: A change on an encoder, index or limit input that lasts fewer than FILT_LEN consecutive samples is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A |
| enc_b | input | 1 | Encoder channel B |
| idx_in | input | 1 | Encoder index pulse |
| lim_in | input | 1 | Limit-switch input |
| run_en | input | 1 | Counting enable |
| res_mode | input | 2 | Decode resolution: 00 x1, 01 x2, 1x x4 |
| clr_mask | input | 3 | Clear-source enables: bit0 index, bit1 limit, bit2 software |
| sw_clr | input | 1 | Software clear request, acts on 0-to-1 |
| position | output | CNT_W | Signed accumulated count |
| dir_up | output | 1 | Direction of the last counted step, 1 = up |
| cleared | output | 1 | High for one cycle after a clear |
| seq_err | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach from the ports is a clear and a counted step landing in the same cycle. Both travel through the synchronisers and the filter, so the stimulus changes channel A and raises the index input in the same input sample. The filter then releases both on the same edge. The same approach gives the illegal double-channel change, where A and B flip together. A cycle-accurate reference model follows every edge, so the exact cycle of each count, clear and error is compared, not only the final value.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W    = 32,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             idx_in,
  input  logic             lim_in,
  input  logic             run_en,
  input  logic [1:0]       res_mode,
  input  logic [2:0]       clr_mask,
  input  logic             sw_clr,
  output logic [CNT_W-1:0] position,
  output logic             dir_up,
  output logic             cleared,
  output logic             seq_err
);
  localparam int NCH = 4;
  localparam int FCW = $clog2(FILT_LEN + 1);

  logic [NCH-1:0] raw, s1, s2, flt, prv;
  assign raw = {lim_in, idx_in, enc_b, enc_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prv <= '0;
    end else begin
      s1 <= raw; s2 <= s1; prv <= flt;
    end

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    logic [FCW-1:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_cnt <= '0; flt[g] <= 1'b0;
      end else if (s2[g] == flt[g]) begin
        run_cnt <= '0;
      end else if (run_cnt == FCW'(FILT_LEN - 1)) begin
        run_cnt <= '0; flt[g] <= s2[g];
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
  end

  logic fa, fb, a_chg, b_chg, illegal, ev, up_step, step, clr, sw_q;
  assign fa      = flt[0];
  assign fb      = flt[1];
  assign a_chg   = fa ^ prv[0];
  assign b_chg   = fb ^ prv[1];
  assign illegal = a_chg & b_chg;

  always_comb begin
    if (res_mode[1]) begin
      ev      = a_chg ^ b_chg;
      up_step = a_chg ? (fa ^ fb) : ~(fa ^ fb);
    end else if (res_mode[0]) begin
      ev      = a_chg & ~b_chg;
      up_step = fa ^ fb;
    end else begin
      ev      = a_chg & ~b_chg & fa;
      up_step = ~fb;
    end
  end

  assign step = run_en & ev;
  assign clr  = (clr_mask[0] & flt[2] & ~prv[2])
              | (clr_mask[1] & flt[3] & ~prv[3])
              | (clr_mask[2] & sw_clr & ~sw_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      position <= '0; dir_up <= 1'b1; cleared <= 1'b0;
      seq_err  <= 1'b0; sw_q <= 1'b0;
    end else begin
      sw_q    <= sw_clr;
      cleared <= clr;
      seq_err <= seq_err | illegal;
      if (step) dir_up <= up_step;
      if (clr)       position <= '0;
      else if (step) position <= up_step ? position + 1'b1 : position - 1'b1;
    end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cleared |-> position == '0);  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);  // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cleared || position == $past(position)));  // R6
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cleared || position == $past(position) || position == $past(position) + 1'b1
              || position == $past(position) - 1'b1));  // R2
  AST_ILLEGAL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[1:0] == ~prv[1:0]) |=> (cleared || position == $past(position)));  // R5
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[1:0] == ~prv[1:0]) |=> seq_err);  // R5
endmodule

// File: tb/quad_pos_counter_tb.sv
module quad_pos_counter_tb_top;
  localparam int CNT_W = 32;
  localparam int FILT  = 3;
  localparam int HOLD  = FILT + 6;

  logic clk = 0, rst_n = 0;
  logic enc_a = 0, enc_b = 0, idx_in = 0, lim_in = 0, run_en = 0, sw_clr = 0;
  logic [1:0] res_mode = 2'b10;
  logic [2:0] clr_mask = 3'b000;
  logic [CNT_W-1:0] position;
  logic dir_up, cleared, seq_err;

  quad_pos_counter #(.CNT_W(CNT_W), .FILT_LEN(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .idx_in(idx_in),
    .lim_in(lim_in), .run_en(run_en), .res_mode(res_mode), .clr_mask(clr_mask),
    .sw_clr(sw_clr), .position(position), .dir_up(dir_up), .cleared(cleared),
    .seq_err(seq_err));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  bit hist[4][FILT+1];
  bit mf[4], mp[4];
  bit m_swq, m_dir, m_clr, m_err;
  logic [CNT_W-1:0] m_pos;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (hist[i, j]) hist[i][j] = 0;
      for (int i = 0; i < 4; i++) begin mf[i] = 0; mp[i] = 0; end
      m_swq = 0; m_dir = 1; m_clr = 0; m_err = 0; m_pos = '0;
    end else begin
      bit ach, bch, ev, up, clr;
      bit nf[4];
      bit cur[4];
      ach = mf[0] != mp[0];
      bch = mf[1] != mp[1];
      ev = 0; up = 0;
      case (res_mode)
        2'b00: begin ev = ach && !bch && mf[0]; up = !mf[1]; end
        2'b01: begin ev = ach && !bch; up = mf[0] != mf[1]; end
        default: begin
          ev = ach != bch;
          up = ach ? (mf[0] != mf[1]) : (mf[0] == mf[1]);
        end
      endcase
      clr = (clr_mask[0] && mf[2] && !mp[2]) || (clr_mask[1] && mf[3] && !mp[3])
         || (clr_mask[2] && sw_clr && !m_swq);
      if (ach && bch) m_err = 1;
      if (run_en && ev) m_dir = up;
      if (clr) m_pos = '0;
      else if (run_en && ev) m_pos = up ? m_pos + 1 : m_pos - 1;
      m_clr = clr;
      m_swq = sw_clr;
      for (int i = 0; i < 4; i++) begin
        bit all;
        all = 1;
        for (int k = 1; k <= FILT; k++) if (hist[i][k] == mf[i]) all = 0;
        nf[i] = all ? !mf[i] : mf[i];
      end
      cur[0] = enc_a; cur[1] = enc_b; cur[2] = idx_in; cur[3] = lim_in;
      for (int i = 0; i < 4; i++) begin
        mp[i] = mf[i];
        mf[i] = nf[i];
        for (int k = FILT; k > 0; k--) hist[i][k] = hist[i][k-1];
        hist[i][0] = cur[i];
      end
    end
  end

  task automatic chk(string what, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("position", position, m_pos);
    chk("dir_up", CNT_W'(dir_up), CNT_W'(m_dir));
    chk("cleared", CNT_W'(cleared), CNT_W'(m_clr));
    chk("seq_err", CNT_W'(seq_err), CNT_W'(m_err));
  end

  int ph = 0;
  task automatic drive_ab(int p);
    @(negedge clk);
    enc_a = (p == 1 || p == 2);
    enc_b = (p == 2 || p == 3);
    repeat (HOLD) @(negedge clk);
  endtask
  task automatic fwd(int n);
    for (int i = 0; i < n; i++) begin ph = (ph + 1) % 4; drive_ab(ph); end
  endtask
  task automatic bwd(int n);
    for (int i = 0; i < n; i++) begin ph = (ph + 3) % 4; drive_ab(ph); end
  endtask
  task automatic pulse(ref logic sig, input int len);
    @(negedge clk); sig = 1;
    repeat (len) @(negedge clk); sig = 0;
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    tag = "R1";
    chk("reset position", position, '0);
    chk("reset dir", CNT_W'(dir_up), 1);
    chk("reset flags", CNT_W'({cleared, seq_err}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    tag = "R2"; run_en = 1; res_mode = 2'b10;
    fwd(8); chk("x4 forward", position, 8);
    bwd(3); chk("x4 reverse", position, 5);
    res_mode = 2'b11; fwd(4); chk("x4 alt code", position, 9);

    tag = "R3"; res_mode = 2'b01;
    fwd(8); chk("x2 forward", position, 13);
    bwd(4); chk("x2 reverse", position, 11);

    tag = "R4"; res_mode = 2'b00;
    fwd(8); chk("x1 forward", position, 13);
    bwd(8); chk("x1 reverse", position, 11);

    tag = "R12"; res_mode = 2'b10;
    pulse(enc_b, FILT - 1);
    pulse(idx_in, FILT - 1);
    chk("short pulse ignored", position, 11);

    tag = "R6"; run_en = 0;
    fwd(5); chk("stopped", position, 11);
    clr_mask = 3'b001; pulse(idx_in, HOLD);
    chk("clear while stopped", position, 0);
    run_en = 1;

    tag = "R7";
    fwd(3);
    pulse(idx_in, HOLD); chk("index clear", position, 0);
    fwd(3); clr_mask = 3'b010;
    pulse(lim_in, HOLD); chk("limit clear", position, 0);
    fwd(3); clr_mask = 3'b100;
    @(negedge clk); sw_clr = 1; repeat (HOLD) @(negedge clk);
    chk("soft clear", position, 0);
    fwd(2); chk("soft held high", position, 2);
    sw_clr = 0; repeat (2) @(negedge clk);

    tag = "R8"; clr_mask = 3'b000;
    pulse(idx_in, HOLD); pulse(lim_in, HOLD);
    @(negedge clk); sw_clr = 1; repeat (HOLD) @(negedge clk); sw_clr = 0;
    chk("masked sources", position, 2);

    tag = "R10";
    fwd(2); clr_mask = 3'b011; fwd(1); clr_mask = 3'b100; fwd(2);
    chk("mask change", position, 7);

    tag = "R9"; clr_mask = 3'b001;
    @(negedge clk);
    ph = (ph + 1) % 4;
    enc_a = (ph == 1 || ph == 2); enc_b = (ph == 2 || ph == 3); idx_in = 1;
    repeat (HOLD) @(negedge clk);
    idx_in = 0; repeat (HOLD) @(negedge clk);
    chk("clear beats step", position, 0);

    tag = "R11"; clr_mask = 3'b000;
    bwd(1); chk("underflow", position, '1);
    fwd(1); chk("wrap back", position, 0);

    tag = "R5";
    @(negedge clk);
    ph = (ph + 2) % 4;
    enc_a = (ph == 1 || ph == 2); enc_b = (ph == 2 || ph == 3);
    repeat (HOLD) @(negedge clk);
    chk("illegal skipped", position, 0);
    chk("error set", CNT_W'(seq_err), 1);
    fwd(2); chk("error sticky", CNT_W'(seq_err), 1);
    chk("count after error", position, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule